// File: doc/BRIEF.md
# Pipelined Ring Allreduce Engine

This block is the per-node sequencer of a ring allreduce. A node on a ring of `ring_size` members holds a vector split into `ring_size` equal segments of `seg_len` words each. The engine streams segments to its downstream neighbour and takes segments from its upstream neighbour. It runs `2*ring_size-2` rounds in total. In the first `ring_size-1` rounds (the reduce epoch) each received word is added into the local buffer. In the remaining rounds (the gather epoch) each received word overwrites the local buffer. When the last round ends, every node holds the element-wise sum of all nodes' vectors. Arithmetic is integer and wraps modulo 2^DATA_W.

The engine has two lanes, and each lane owns a stream pair and a port onto the local buffer. Lane 0 always runs and moves data toward the next rank. When `bidir` is high at start, lane 1 also runs at the same time on a second half of the buffer, in the opposite ring direction. The buffer itself lives outside the block and is read combinationally. A write uses the same address as the accumulate read.

The controller has four states:
- ST_IDLE: waits for `start`, then latches the configuration and moves to ST_ROUND.
- ST_ROUND: moves data until every active lane has finished its segment in both directions. It then goes to ST_NEXT, or to ST_FINISH after the final round.
- ST_NEXT: bumps the round counter and returns to ST_ROUND.
- ST_FINISH: raises `done` for one cycle and returns to ST_IDLE.

Top module: `ring_ar_engine`

## Requirements
- R1: After reset, `tx_valid`, `rx_ready`, `wr_en` and `done` are all low until a `start` is seen.
- R2: Segment s of lane 0 occupies buffer words s*seg_len to s*seg_len+seg_len-1. Segment s of lane 1 occupies the same words offset by ring_size*seg_len. Words within a segment are sent and received in ascending address order.
- R3: In reduce round r (0 <= r <= ring_size-2), lane 0 sends segment (rank-r) mod ring_size. It also receives segment (rank-r-1) mod ring_size and writes back the sum of the buffer word and the received word.
- R4: In gather rounds r = ring_size-1 to 2*ring_size-3, the same segment rotation applies, but the received word is written unchanged.
- R5: With `bidir` high, lane 1 sends segment (rank+r) mod ring_size and receives segment (rank+r+1) mod ring_size, with the same add and overwrite rules per epoch.
- R6: With `bidir` low, lane 1 never raises `tx_valid` or `rx_ready` and writes nothing.
- R7: A round ends only after seg_len words have been accepted on every active lane's send stream and seg_len words have been taken on its receive stream. While `tx_valid` waits for `tx_ready`, the word stays offered at the same address.
- R8: `done` is high for exactly one cycle after the last gather round completes. At that point, every used buffer word holds the sum over all ring members of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in ST_IDLE) |
| bidir | input | 1 | Enable lane 1, which runs in the opposite ring direction |
| rank | input | RANK_W | This node's position on the ring |
| ring_size | input | NODE_W | Number of ring members, 2..MAX_NODES |
| seg_len | input | ADDR_W | Words per segment per lane, at least 1 |
| done | output | 1 | One-cycle completion pulse |
| tx_valid | output | LANES | Send stream valid, per lane |
| tx_ready | input | LANES | Send stream ready, per lane |
| tx_data | output | LANES*DATA_W | Send stream word, per lane |
| rx_valid | input | LANES | Receive stream valid, per lane |
| rx_ready | output | LANES | Receive stream ready, per lane |
| rx_data | input | LANES*DATA_W | Receive stream word, per lane |
| snd_addr | output | LANES*ADDR_W | Buffer read address for the outgoing word |
| snd_rdata | input | LANES*DATA_W | Buffer word at snd_addr |
| acc_addr | output | LANES*ADDR_W | Buffer read and write address for the incoming word |
| acc_rdata | input | LANES*DATA_W | Buffer word at acc_addr |
| wr_en | output | LANES | Buffer write strobe at acc_addr |
| wr_data | output | LANES*DATA_W | Buffer write word |

## Verification
The hardest case to reach is a node whose upstream and downstream streams stall in different patterns, so that one direction of a round finishes well before the other and the round barrier must hold. The same case must also occur on both lanes at once, with the rotation wrapping around rank 0 in opposite directions. The bench plays every other ring member arithmetically, for every rank on rings of two to five nodes, at two segment lengths and in both modes. It applies independent, skewed ready and valid patterns per lane and per direction. Each outgoing word, each written word and the final buffer are predicted from closed-form partial sums over neighbour ranks.

// File: rtl/ring_ar_pkg.sv
package ring_ar_pkg;

    localparam int unsigned AR_LANES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROUND,
        ST_NEXT,
        ST_FINISH
    } ar_state_e;

endpackage

// File: rtl/ring_ar_sched.sv
// Per-lane segment rotation: maps rank and round to the send and receive
// segment base addresses. DIR 0 walks toward lower ranks, DIR 1 toward higher.
module ring_ar_sched #(
    parameter int unsigned NODE_W = 6,
    parameter int unsigned RANK_W = 5,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DIR    = 0,
    localparam int unsigned CNT_W = NODE_W + 1
) (
    input  logic [RANK_W-1:0] rank,
    input  logic [NODE_W-1:0] ring_size,
    input  logic [CNT_W-1:0]  round,
    input  logic [ADDR_W-1:0] seg_len,
    input  logic [ADDR_W-1:0] lane_base,
    output logic [ADDR_W-1:0] snd_base,
    output logic [ADDR_W-1:0] rcv_base
);

    logic [CNT_W-1:0] rk, pp, rm, snd_seg, rcv_seg;

    assign rk = CNT_W'(rank);
    assign pp = CNT_W'(ring_size);
    assign rm = (round >= pp) ? round - pp : round;

    generate
        if (DIR == 0) begin : g_down
            assign snd_seg = (rk >= rm) ? rk - rm : rk + pp - rm;
            assign rcv_seg = (snd_seg == '0) ? pp - 1'b1 : snd_seg - 1'b1;
        end else begin : g_up
            logic [CNT_W-1:0] sum;
            assign sum     = rk + rm;
            assign snd_seg = (sum >= pp) ? sum - pp : sum;
            assign rcv_seg = (snd_seg == pp - 1'b1) ? '0 : snd_seg + 1'b1;
        end
    endgenerate

    assign snd_base = lane_base + ADDR_W'(snd_seg) * seg_len;
    assign rcv_base = lane_base + ADDR_W'(rcv_seg) * seg_len;

endmodule

// File: rtl/ring_ar_lane.sv
// One ring direction: word counters, stream handshakes and buffer
// read/modify/write for the current round.
module ring_ar_lane #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              reduce,
    input  logic [ADDR_W-1:0] seg_len,
    input  logic [ADDR_W-1:0] snd_base,
    input  logic [ADDR_W-1:0] rcv_base,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic [ADDR_W-1:0] snd_addr,
    input  logic [DATA_W-1:0] snd_rdata,
    output logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              seg_done
);

    logic [ADDR_W-1:0] snd_cnt, rcv_cnt;
    logic              tx_fire, rx_fire;

    assign tx_valid = go && (snd_cnt != seg_len);
    assign rx_ready = go && (rcv_cnt != seg_len);
    assign tx_fire  = tx_valid && tx_ready;
    assign rx_fire  = rx_valid && rx_ready;

    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            snd_cnt <= '0;
            rcv_cnt <= '0;
        end else begin
            if (tx_fire) snd_cnt <= snd_cnt + 1'b1;
            if (rx_fire) rcv_cnt <= rcv_cnt + 1'b1;
        end
    end

    assign snd_addr = snd_base + snd_cnt;
    assign acc_addr = rcv_base + rcv_cnt;
    assign tx_data  = snd_rdata;
    assign wr_en    = rx_fire;
    assign wr_data  = reduce ? acc_rdata + rx_data : rx_data;
    assign seg_done = (snd_cnt == seg_len) && (rcv_cnt == seg_len);

endmodule

// File: rtl/ring_ar_engine.sv
module ring_ar_engine
    import ring_ar_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned MAX_NODES = 32,
    localparam int unsigned RANK_W   = $clog2(MAX_NODES),
    localparam int unsigned NODE_W   = $clog2(MAX_NODES + 1),
    localparam int unsigned LANES    = AR_LANES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          bidir,
    input  logic [RANK_W-1:0]             rank,
    input  logic [NODE_W-1:0]             ring_size,
    input  logic [ADDR_W-1:0]             seg_len,
    output logic                          done,
    output logic [LANES-1:0]              tx_valid,
    input  logic [LANES-1:0]              tx_ready,
    output logic [LANES-1:0][DATA_W-1:0]  tx_data,
    input  logic [LANES-1:0]              rx_valid,
    output logic [LANES-1:0]              rx_ready,
    input  logic [LANES-1:0][DATA_W-1:0]  rx_data,
    output logic [LANES-1:0][ADDR_W-1:0]  snd_addr,
    input  logic [LANES-1:0][DATA_W-1:0]  snd_rdata,
    output logic [LANES-1:0][ADDR_W-1:0]  acc_addr,
    input  logic [LANES-1:0][DATA_W-1:0]  acc_rdata,
    output logic [LANES-1:0]              wr_en,
    output logic [LANES-1:0][DATA_W-1:0]  wr_data
);

    localparam int unsigned CNT_W = NODE_W + 1;

    ar_state_e         state_q, state_d;
    logic [RANK_W-1:0] rank_q;
    logic [NODE_W-1:0] size_q;
    logic [ADDR_W-1:0] len_q;
    logic              bidir_q;
    logic [CNT_W-1:0]  round_q;

    logic              in_round, reduce, last_round, all_done;
    logic [LANES-1:0]  lane_act, lane_done;

    assign last_round = (round_q == CNT_W'({size_q, 1'b0}) - CNT_W'(3));
    assign reduce     = (round_q < CNT_W'(size_q) - 1'b1);
    assign lane_act   = {bidir_q, 1'b1};
    assign all_done   = &(lane_done | ~lane_act);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ROUND;
            ST_ROUND:  if (all_done) state_d = last_round ? ST_FINISH : ST_NEXT;
            ST_NEXT:   state_d = ST_ROUND;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state, configuration and round registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rank_q  <= '0;
            size_q  <= NODE_W'(2);
            len_q   <= '0;
            bidir_q <= 1'b0;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                rank_q  <= rank;
                size_q  <= ring_size;
                len_q   <= seg_len;
                bidir_q <= bidir;
                round_q <= '0;
            end else if (state_q == ST_NEXT) begin
                round_q <= round_q + 1'b1;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        in_round = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ROUND:  in_round = 1'b1;
            ST_NEXT:   ;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [ADDR_W-1:0] base, sb, rb;
            assign base = (l == 0) ? '0 : ADDR_W'(size_q) * len_q;

            ring_ar_sched #(
                .NODE_W (NODE_W),
                .RANK_W (RANK_W),
                .ADDR_W (ADDR_W),
                .DIR    (l)
            ) u_sched (
                .rank      (rank_q),
                .ring_size (size_q),
                .round     (round_q),
                .seg_len   (len_q),
                .lane_base (base),
                .snd_base  (sb),
                .rcv_base  (rb)
            );

            ring_ar_lane #(
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W)
            ) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .go        (in_round && lane_act[l]),
                .reduce    (reduce),
                .seg_len   (len_q),
                .snd_base  (sb),
                .rcv_base  (rb),
                .tx_valid  (tx_valid[l]),
                .tx_ready  (tx_ready[l]),
                .tx_data   (tx_data[l]),
                .rx_valid  (rx_valid[l]),
                .rx_ready  (rx_ready[l]),
                .rx_data   (rx_data[l]),
                .snd_addr  (snd_addr[l]),
                .snd_rdata (snd_rdata[l]),
                .acc_addr  (acc_addr[l]),
                .acc_rdata (acc_rdata[l]),
                .wr_en     (wr_en[l]),
                .wr_data   (wr_data[l]),
                .seg_done  (lane_done[l])
            );
        end
    endgenerate

endmodule

// File: rtl/ring_ar_engine_chk.sv
module ring_ar_engine_chk #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned ADDR_W = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         done,
    input logic                         bidir_q,
    input logic [LANES-1:0]             tx_valid,
    input logic [LANES-1:0]             tx_ready,
    input logic [LANES-1:0]             rx_ready,
    input logic [LANES-1:0]             wr_en,
    input logic [LANES-1:0][ADDR_W-1:0] snd_addr,
    input logic [LANES-1:0][ADDR_W-1:0] acc_addr
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_valid == '0) && (rx_ready == '0));

    // R6
    lane1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid[1] || rx_ready[1] || wr_en[1]) |-> bidir_q);

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_chk
            // R7
            tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[l] && !tx_ready[l]) |=> (tx_valid[l] && $stable(snd_addr[l])));

            // R3
            seg_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[l] && tx_valid[l]) |-> (acc_addr[l] != snd_addr[l]));
        end
    endgenerate

endmodule

bind ring_ar_engine ring_ar_engine_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .bidir_q  (bidir_q),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_ready (rx_ready),
    .wr_en    (wr_en),
    .snd_addr (snd_addr),
    .acc_addr (acc_addr)
);

// File: tb/tb_ring_ar_engine.sv
`timescale 1ns/1ps
module tb_ring_ar_engine;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;
    localparam int LANES  = 2;
    localparam int MEMN   = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                         rst_n, start, bidir, done;
    logic [4:0]                   rank;
    logic [5:0]                   ring_size;
    logic [ADDR_W-1:0]            seg_len;
    logic [LANES-1:0]             tx_valid, tx_ready, rx_valid, rx_ready, wr_en;
    logic [LANES-1:0][DATA_W-1:0] tx_data, rx_data, snd_rdata, acc_rdata, wr_data;
    logic [LANES-1:0][ADDR_W-1:0] snd_addr, acc_addr;

    logic [DATA_W-1:0] mem [0:MEMN-1];

    int tests = 0;
    int fails = 0;

    ring_ar_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bidir(bidir), .rank(rank),
        .ring_size(ring_size), .seg_len(seg_len), .done(done),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .snd_addr(snd_addr), .snd_rdata(snd_rdata),
        .acc_addr(acc_addr), .acc_rdata(acc_rdata),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            snd_rdata[l] = mem[snd_addr[l] % MEMN];
            acc_rdata[l] = mem[acc_addr[l] % MEMN];
        end
    end

    function automatic int modp(int x, int p);
        return ((x % p) + p) % p;
    endfunction

    function automatic logic [DATA_W-1:0] initv(int k, int a);
        return DATA_W'(k * 20011 + a * 13 + 7);
    endfunction

    // sum over nodes node + dir*(first .. first+cnt-1), word address a
    function automatic logic [DATA_W-1:0] psum(int node, int dir, int first, int cnt, int p, int a);
        logic [DATA_W-1:0] s = '0;
        for (int t = 0; t < cnt; t++) s = s + initv(modp(node + dir * (first + t), p), a);
        return s;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic run_case(int p, int i, int len, int bd);
        int tot, dir, seg, a, r, w, cyc, done_cnt, base;
        int tx_idx [LANES];
        int rx_idx [LANES];
        logic [DATA_W-1:0] exp;
        bit finished;
        tot = (2 * p - 2) * len;
        for (int a2 = 0; a2 < MEMN; a2++) mem[a2] = initv(i, a2);
        for (int l = 0; l < LANES; l++) begin tx_idx[l] = 0; rx_idx[l] = 0; end
        done_cnt = 0; finished = 0; cyc = 0;
        @(negedge clk);
        rank = 5'(i); ring_size = 6'(p); seg_len = ADDR_W'(len); bidir = bd[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!finished && cyc < 3000) begin
            cyc++;
            for (int l = 0; l < LANES; l++) begin
                dir  = (l == 0) ? -1 : 1;
                base = l * p * len;
                tx_ready[l] = (((cyc * 3 + l + i) % 4) != 0);
                rx_valid[l] = (((cyc * 5 + 2 * l + p) % 3) != 0) && (rx_idx[l] < tot);
                r = rx_idx[l] / len; w = rx_idx[l] % len;
                seg = modp(i + dir * (r + 1), p);
                a = base + seg * len + w;
                rx_data[l] = (r < p - 1) ? psum(i, dir, 1, r + 1, p, a) : psum(i, dir, 0, p, p, a);
            end
            #1;
            for (int l = 0; l < LANES; l++) begin
                dir  = (l == 0) ? -1 : 1;
                base = l * p * len;
                if (l == 1 && bd == 0)
                    check("R6 lane1 idle", {30'd0, tx_valid[1], rx_ready[1] | wr_en[1]}, 32'd0);
                if (tx_valid[l] && tx_ready[l]) begin
                    r = tx_idx[l] / len; w = tx_idx[l] % len;
                    seg = modp(i + dir * r, p);
                    a = base + seg * len + w;
                    exp = (r < p - 1) ? psum(i, dir, 0, r + 1, p, a) : psum(i, dir, 0, p, p, a);
                    check(l == 0 ? ((r < p - 1) ? "R3 tx word" : "R4 tx word") : "R5 tx word",
                          {tx_data[l], 6'd0, snd_addr[l]}, {exp, 6'd0, ADDR_W'(a)});
                    tx_idx[l]++;
                end
                if (rx_valid[l] && rx_ready[l]) begin
                    r = rx_idx[l] / len; w = rx_idx[l] % len;
                    seg = modp(i + dir * (r + 1), p);
                    a = base + seg * len + w;
                    exp = (r < p - 1) ? psum(i, dir, 0, r + 2, p, a) : psum(i, dir, 0, p, p, a);
                    check(l == 0 ? ((r < p - 1) ? "R3 wr word" : "R4 wr word") : "R5 wr word",
                          {wr_en[l], wr_data[l], 5'd0, acc_addr[l]}, {1'b1, exp, 5'd0, ADDR_W'(a)});
                    mem[acc_addr[l] % MEMN] = wr_data[l];
                    rx_idx[l]++;
                end
            end
            if (done) begin
                done_cnt++;
                finished = 1;
                // R7: round barrier means all traffic is complete at done
                check("R7 tx count lane0", tx_idx[0], tot);
                check("R7 rx count lane0", rx_idx[0], tot);
                check("R7 tx count lane1", tx_idx[1], bd ? tot : 0);
                check("R7 rx count lane1", rx_idx[1], bd ? tot : 0);
            end
            @(negedge clk);
        end
        if (!finished) check("R8 done seen (timeout)", 0, 1);
        for (int k = 0; k < 3; k++) begin
            #1;
            if (done) done_cnt++;
            @(negedge clk);
        end
        check("R8 done once", done_cnt, 1);
        for (int a2 = 0; a2 < 2 * p * len; a2++) begin
            if (a2 < p * len || bd)
                check("R8 final sum", mem[a2], psum(i, 1, 0, p, p, a2));
            else
                check("R6 lane1 half untouched", mem[a2], initv(i, a2));
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; bidir = 1'b0; rank = '0; ring_size = 6'd2;
        seg_len = ADDR_W'(1); tx_ready = '0; rx_valid = '0; rx_data = '0;
        for (int a2 = 0; a2 < MEMN; a2++) mem[a2] = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset outputs", {28'd0, tx_valid, rx_ready}, 32'd0);
        check("R1 reset done/wr", {29'd0, done, wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 idle after reset", {27'd0, done, tx_valid, rx_ready}, 32'd0);
        // R2 addressing is checked through snd_addr/acc_addr in every word check
        for (int p = 2; p <= 5; p++)
            for (int i = 0; i < p; i++)
                for (int li = 0; li < 2; li++)
                    for (int bd = 0; bd < 2; bd++)
                        run_case(p, i, (li == 0) ? 1 : 3, bd);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule